// File: doc/BRIEF.md
# Interrupt Register with Halt Aggregation

This block holds a row of latched interrupt bits and reduces them to two request lines for the rest of the chip. Hardware raises a bit with a one-cycle pulse on its set input. Software clears it by writing a one to it through a small write/read port. A second register holds four gating bits for each field: a normal-path mask, a normal-path enable, a halt-path mask and a halt-path enable.

Elaboration-time parameters decide which of those gating bits each field actually uses. A mask blocks a field when it is set. An enable lets a field through only when it is set. When a field is configured with both, the mask decides. A field with no gating passes its raw bit.

The interrupt line is the OR of every gated field. The halt line is built the same way from the halt gating, but only when at least one field has halt gating configured. Otherwise the halt line is held low. Both lines are combinational functions of the stored bits.

Top module: `intr_halt_reg`

## Requirements
- R1: After reset every status bit and every control bit is 0, and `intr_o` and `halt_o` are 0.
- R2: A 1 on `hw_set_i[k]` sets status bit k at the next rising clock edge. The bit then stays set with no further pulse. A status bit never becomes 1 without a set pulse.
- R3: A write to address 0 clears each status bit whose `wr_data_i` bit is 1 and leaves the other status bits unchanged. If a set pulse and a clearing write reach the same bit in the same cycle, the bit ends up 1.
- R4: A write to address 1 loads the control register at the next edge. Its layout for N fields is: bits [N-1:0] normal mask, [2N-1:N] normal enable, [3N-1:2N] halt mask, [4N-1:3N] halt enable.
- R5: A field configured with a normal mask contributes status AND NOT mask to `intr_o`.
- R6: A field configured with only a normal enable contributes status AND enable to `intr_o`.
- R7: A field with no gating configured for a path contributes its raw status bit to that path.
- R8: A field configured with both a mask and an enable on the same path is gated by the mask alone, and its enable bit has no effect.
- R9: `intr_o` is the OR of all fields' normal-path contributions. It follows the stored bits in the same cycle, with no added register stage.
- R10: `halt_o` follows rules R5 to R8, using the halt mask and halt enable in place of the normal mask and enable.
- R11: When no field has halt gating configured, `halt_o` stays 0 whatever the status and control contents are.
- R12: `rd_data_o` returns the status bits zero-extended when `rd_addr_i` is 0, and the control register when `rd_addr_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hw_set_i | input | NUM_FIELDS | Per-field set pulses |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 1 | Write address: 0 status, 1 control |
| wr_data_i | input | 4*NUM_FIELDS | Write data |
| rd_addr_i | input | 1 | Read address: 0 status, 1 control |
| rd_data_o | output | 4*NUM_FIELDS | Read data |
| intr_o | output | 1 | Aggregated interrupt |
| halt_o | output | 1 | Aggregated halt |

## Verification
Each field's gating style is tried with its single status bit raised, once with the gating bit clear and once with it set. This separates masks from enables and shows that a field with no gating passes its raw bit. The fields configured with both a mask and an enable are driven with only the enable set and with both set, which shows that the mask takes precedence. Random status and control patterns are then checked every time against a bench model. A second copy of the block with no halt gating shows that the halt line stays low. Directed cases cover clearing selected bits and a set pulse that coincides with a clear.

// File: rtl/intr_reg_pkg.sv
package intr_reg_pkg;
  // Register select on the write/read port
  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_CTRL   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/intr_status_bank.sv
module intr_status_bank #(
  parameter int NUM_FIELDS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_FIELDS-1:0] hw_set_i,
  input  logic                  clr_we_i,
  input  logic [NUM_FIELDS-1:0] clr_bits_i,
  output logic [NUM_FIELDS-1:0] status_o
);
  logic [NUM_FIELDS-1:0] status_q, status_d;
  logic                  status_en;

  // Set beats clear: OR in the set pulses after clearing
  always_comb begin
    status_en = clr_we_i | (|hw_set_i);
    status_d  = (status_q & ~(clr_we_i ? clr_bits_i : '0)) | hw_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        status_q <= '0;
    else if (status_en) status_q <= status_d;
  end

  assign status_o = status_q;

  // R2: a set pulse lands on the next edge
  p_set_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hw_set_i) |=> ((status_q & $past(hw_set_i)) == $past(hw_set_i)));

  // R2: no bit rises without a set pulse
  p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q & ~$past(status_q) & ~$past(hw_set_i)) == '0);

  // R3: written ones clear, unless a set pulse coincides
  p_w1c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && |(clr_bits_i & ~hw_set_i))
      |=> ((status_q & $past(clr_bits_i & ~hw_set_i)) == '0));
endmodule

// File: rtl/intr_ctrl_reg.sv
module intr_ctrl_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] ctrl_o
);
  logic [WIDTH-1:0] ctrl_q, ctrl_d;

  always_comb ctrl_d = wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (we_i) ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  // R4: a control write is visible on the next edge
  p_ctrl_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (ctrl_q == $past(wdata_i)));
endmodule

// File: rtl/intr_gate_or.sv
module intr_gate_or #(
  parameter int                    NUM_FIELDS = 4,
  parameter logic [NUM_FIELDS-1:0] INV_SEL    = '0,
  parameter logic [NUM_FIELDS-1:0] POS_SEL    = '0
) (
  input  logic [NUM_FIELDS-1:0] status_i,
  input  logic [NUM_FIELDS-1:0] inv_i,
  input  logic [NUM_FIELDS-1:0] pos_i,
  output logic                  any_o
);
  logic [NUM_FIELDS-1:0] contrib;

  // Per field: inverted gate wins, then non-inverted gate, else raw bit
  always_comb begin
    for (int k = 0; k < NUM_FIELDS; k++) begin
      contrib[k] = status_i[k] &
                   (INV_SEL[k] ? ~inv_i[k] : (POS_SEL[k] ? pos_i[k] : 1'b1));
    end
  end

  assign any_o = |contrib;
endmodule

// File: rtl/intr_halt_reg.sv
module intr_halt_reg
  import intr_reg_pkg::*;
#(
  parameter int                    NUM_FIELDS = 4,
  parameter logic [NUM_FIELDS-1:0] MASK_SEL   = 4'b0011,
  parameter logic [NUM_FIELDS-1:0] EN_SEL     = 4'b0110,
  parameter logic [NUM_FIELDS-1:0] HMASK_SEL  = 4'b1000,
  parameter logic [NUM_FIELDS-1:0] HEN_SEL    = 4'b1001,
  localparam int                   DW         = 4 * NUM_FIELDS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_FIELDS-1:0] hw_set_i,
  input  logic                  wr_en_i,
  input  logic                  wr_addr_i,
  input  logic [DW-1:0]         wr_data_i,
  input  logic                  rd_addr_i,
  output logic [DW-1:0]         rd_data_o,
  output logic                  intr_o,
  output logic                  halt_o
);
  localparam bit HALT_PRESENT = |(HMASK_SEL | HEN_SEL);

  logic [NUM_FIELDS-1:0] status;
  logic [DW-1:0]         ctrl;
  logic                  status_we, ctrl_we;

  assign status_we = wr_en_i && (reg_sel_e'(wr_addr_i) == SEL_STATUS);
  assign ctrl_we   = wr_en_i && (reg_sel_e'(wr_addr_i) == SEL_CTRL);

  intr_status_bank #(.NUM_FIELDS(NUM_FIELDS)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hw_set_i   (hw_set_i),
    .clr_we_i   (status_we),
    .clr_bits_i (wr_data_i[NUM_FIELDS-1:0]),
    .status_o   (status)
  );

  intr_ctrl_reg #(.WIDTH(DW)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we),
    .wdata_i (wr_data_i),
    .ctrl_o  (ctrl)
  );

  intr_gate_or #(
    .NUM_FIELDS (NUM_FIELDS),
    .INV_SEL    (MASK_SEL),
    .POS_SEL    (EN_SEL)
  ) u_intr_gate (
    .status_i (status),
    .inv_i    (ctrl[NUM_FIELDS-1:0]),
    .pos_i    (ctrl[2*NUM_FIELDS-1:NUM_FIELDS]),
    .any_o    (intr_o)
  );

  generate
    if (HALT_PRESENT) begin : g_halt
      intr_gate_or #(
        .NUM_FIELDS (NUM_FIELDS),
        .INV_SEL    (HMASK_SEL),
        .POS_SEL    (HEN_SEL)
      ) u_halt_gate (
        .status_i (status),
        .inv_i    (ctrl[3*NUM_FIELDS-1:2*NUM_FIELDS]),
        .pos_i    (ctrl[4*NUM_FIELDS-1:3*NUM_FIELDS]),
        .any_o    (halt_o)
      );

      // R10: halt never raised without a stored bit
      p_halt_needs_bit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        halt_o |-> (|status));
    end else begin : g_no_halt
      assign halt_o = 1'b0;
    end
  endgenerate

  always_comb begin
    if (reg_sel_e'(rd_addr_i) == SEL_CTRL) rd_data_o = ctrl;
    else rd_data_o = {{(DW-NUM_FIELDS){1'b0}}, status};
  end

  // R9: interrupt never raised without a stored bit
  p_intr_needs_bit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_o |-> (|status));
endmodule

// File: tb/intr_halt_reg_tb.sv
module intr_halt_reg_tb_top;
  localparam int N  = 4;
  localparam int DW = 4 * N;
  localparam logic [N-1:0] MSEL  = 4'b0011;
  localparam logic [N-1:0] ESEL  = 4'b0110;
  localparam logic [N-1:0] HMSEL = 4'b1000;
  localparam logic [N-1:0] HESEL = 4'b1001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] hw_set = '0;
  logic wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data, rd_data_nh;
  logic intr, halt, intr_nh, halt_nh;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  intr_halt_reg #(.NUM_FIELDS(N), .MASK_SEL(MSEL), .EN_SEL(ESEL),
                  .HMASK_SEL(HMSEL), .HEN_SEL(HESEL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hw_set_i(hw_set), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .intr_o(intr), .halt_o(halt));

  // Variant with no halt gating at all
  intr_halt_reg #(.NUM_FIELDS(N), .MASK_SEL(MSEL), .EN_SEL(ESEL),
                  .HMASK_SEL('0), .HEN_SEL('0)) dut_nohalt_i (
    .clk_i(clk), .rst_ni(rst_n), .hw_set_i(hw_set), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data_nh), .intr_o(intr_nh), .halt_o(halt_nh));

  // Vector: {set, ctrl, expected intr, expected halt}
  typedef struct packed {
    logic [N-1:0]  set;
    logic [DW-1:0] ctrl;
    logic          e_intr;
    logic          e_halt;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{4'b0001, 16'h0000, 1'b1, 1'b0},  // R5 mask clear, R10 halt enable clear
    '{4'b0001, 16'h0001, 1'b0, 1'b0},  // R5 mask set
    '{4'b0001, 16'h1000, 1'b1, 1'b1},  // R10 halt enable set
    '{4'b0010, 16'h0020, 1'b1, 1'b1},  // R8 enable ignored, R7 raw halt
    '{4'b0010, 16'h0002, 1'b0, 1'b1},  // R8 mask decides
    '{4'b0100, 16'h0000, 1'b0, 1'b1},  // R6 enable clear, R7 raw halt
    '{4'b0100, 16'h0040, 1'b1, 1'b1},  // R6 enable set
    '{4'b1000, 16'h0800, 1'b1, 1'b0},  // R7 raw intr, R10 halt mask set
    '{4'b1000, 16'h8000, 1'b1, 1'b1},  // R10 halt enable ignored under halt mask
    '{4'b1000, 16'h8800, 1'b1, 1'b0},  // R10 halt mask decides
    '{4'b0000, 16'hFFFF, 1'b0, 1'b0},  // R9 nothing stored
    '{4'b0101, 16'h1001, 1'b0, 1'b1}   // R9 mixed fields
  };

  function automatic logic [1:0] model(input logic [N-1:0] s, input logic [DW-1:0] c);
    logic i_any = 1'b0, h_any = 1'b0, g;
    for (int k = 0; k < N; k++) begin
      g = MSEL[k] ? ~c[k] : (ESEL[k] ? c[N+k] : 1'b1);
      i_any |= s[k] & g;
      g = HMSEL[k] ? ~c[2*N+k] : (HESEL[k] ? c[3*N+k] : 1'b1);
      h_any |= s[k] & g;
    end
    return {i_any, h_any};
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input logic [N-1:0] v);
    @(negedge clk); hw_set = v;
    @(negedge clk); hw_set = '0;
  endtask

  task automatic rd(input logic a, output logic [DW-1:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic [N-1:0]  s;
    logic [DW-1:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    rd(1'b0, d); chk("R1 status", d, '0);
    rd(1'b1, d); chk("R1 ctrl", d, '0);
    chk("R1 intr", DW'(intr), '0);
    chk("R1 halt", DW'(halt), '0);

    // Table walk
    foreach (VECS[v]) begin
      wr(1'b0, DW'({N{1'b1}}));
      wr(1'b1, VECS[v].ctrl);
      pulse(VECS[v].set);
      #1;
      chk($sformatf("R9 intr vector %0d", v), DW'(intr), DW'(VECS[v].e_intr));
      chk($sformatf("R10 halt vector %0d", v), DW'(halt), DW'(VECS[v].e_halt));
      rd(1'b0, d); chk($sformatf("R12 status read vector %0d", v), d, DW'(VECS[v].set));
      rd(1'b1, d); chk($sformatf("R4 ctrl read vector %0d", v), d, VECS[v].ctrl);
    end

    // R2 bits persist, R3 partial clear
    wr(1'b0, DW'({N{1'b1}}));
    wr(1'b1, '0);
    pulse(4'b0011);
    repeat (3) @(negedge clk);
    #1; rd(1'b0, d); chk("R2 bits held", d, DW'(4'b0011));
    wr(1'b0, DW'(4'b0001));
    #1; rd(1'b0, d); chk("R3 partial clear", d, DW'(4'b0010));

    // R3 set wins over a coincident clear
    @(negedge clk); hw_set = 4'b0010; wr_en = 1'b1; wr_addr = 1'b0; wr_data = DW'(4'b0010);
    @(negedge clk); hw_set = '0; wr_en = 1'b0; wr_data = '0;
    #1; rd(1'b0, d); chk("R3 set beats clear", d, DW'(4'b0010));

    // R11 variant without halt gating
    wr(1'b1, 16'h0000);
    pulse(4'b1111);
    #1; chk("R11 halt held low", DW'(halt_nh), '0);
    chk("R11 intr still works", DW'(intr_nh), DW'(1'b1));
    wr(1'b1, 16'hF0F0);
    #1; chk("R11 halt low any ctrl", DW'(halt_nh), '0);

    // Random patterns against the model (R5 to R10)
    for (int r = 0; r < 60; r++) begin
      s = N'($urandom);
      c = DW'($urandom);
      wr(1'b0, DW'({N{1'b1}}));
      wr(1'b1, c);
      pulse(s);
      #1;
      chk("R9 random intr", DW'(intr), DW'(model(s, c) >> 1));
      chk("R10 random halt", DW'(halt), DW'(model(s, c) & 2'b01));
      chk("R11 random no-halt variant", DW'(halt_nh), '0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule